// File: doc/BRIEF.md
# Command-Processor Decode and Execute Stage

This block is the combinational heart of a small 32-bit microcontroller that runs command-stream firmware. Each cycle it takes one instruction word plus the two register values the register file has already fetched. From these it produces four things: the decoded opcode with its repeat flag, the index of the register to write, and the 32-bit result. The opcode header has a variable length. Low header values carry a 5-bit opcode followed by a repeat bit. Header values of 0x30 and above are a whole 6-bit opcode and carry no repeat bit.

The stage executes three instruction families. The first is the ALU operations with a 16-bit unsigned immediate. The second is the same operations in a two-register form, selected by opcode 0x13, which adds a highest-set-bit finder. The third is move-immediate with a left shift. Control-register and sequencing opcodes are not executed here. They are only flagged, so that a later stage can act on them.

The block holds one piece of state: a carry/borrow flag. An add or subtract stores it when the execute strobe is high. The high-word variants then consume it, so two consecutive instructions form one 64-bit add or subtract.

Top module: `mcx_exec_stage`

## Requirements
- R1: The header is instr[31:26]. If the header is below 0x30, opcode = {0, header[5:1]} and rep = header[0]. Otherwise opcode = header and rep = 0.
- R2: Opcodes 0x01 to 0x10 are the immediate form. The first operand is src_a, the second operand is instr[15:0] zero-extended, and dst = instr[20:16]. src_b has no effect.
- R3: Opcode 0x13 is the two-register form. The function code is instr[4:0], the operands are src_a then src_b, and dst = instr[15:11]. Function codes 0x01 to 0x10 and 0x14 give results. Every other code gives 0.
- R4: The function codes behave as follows:
  - 0x01 gives a+b.
  - 0x03 gives a-b.
  - 0x05 gives AND, 0x06 gives OR and 0x07 gives XOR.
  - 0x08 gives ~b and ignores a.
  - 0x00 (no-op) gives 0.
- R5: The shift and rotate codes use b[4:0] as the shift amount:
  - 0x09 shifts left.
  - 0x0a shifts right, logical.
  - 0x0b shifts right, arithmetic.
  - 0x0c rotates left.
- R6: 0x0d gives a[7:0]*b[7:0], zero-extended. 0x0e gives the unsigned minimum and 0x0f gives the unsigned maximum.
- R7: 0x10 compares a with b, unsigned. It gives 0 when they are equal, 1 when a > b and 2 when a < b.
- R8: Two-register function 0x14 gives the index of the highest set bit of src_b, and 0 when src_b is 0 or 1. src_a is ignored.
- R9: Opcode 0x11 gives instr[15:0] << instr[25:21], truncated to 32 bits, with dst = instr[20:16].
- R10: The carry/borrow flag works as follows:
  - Reset clears it.
  - On a rising clock edge with exec_en high, functions 0x01 and 0x02 store their carry-out, and functions 0x03 and 0x04 store their borrow.
  - 0x02 gives a+b+flag and 0x04 gives a-b-flag.
  - Without exec_en, the flag holds.
- R11: ctrl_op is high for opcodes 0x14 to 0x17. seq_op is high for opcodes 0x30 and above. For both of these, and for the no-op, the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe; lets add/sub update the carry flag |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value (two-register form) |
| opcode | output | 6 | Decoded opcode |
| rep | output | 1 | Repeat flag |
| dst | output | 5 | Destination register index |
| result | output | 32 | Execution result |
| ctrl_op | output | 1 | Control-register instruction |
| seq_op | output | 1 | Sequencing instruction (branch, call, return, wait) |

## Verification
All decode outputs and results are combinational and due in the same cycle as the instruction. The bench changes inputs on the falling edge and samples 1 ns later, well before the next rising edge. Only the carry flag needs a rising edge. The result of a high-word instruction therefore depends on the strobed add or subtract one edge earlier. The bench keeps its own copy of the flag and updates it only after checking an instruction that was driven with exec_en high, so each expected value uses the flag as it stands after that edge.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
   localparam int unsigned INSTR_W = 32;
   localparam int unsigned IMM_W   = 16;
   localparam int unsigned RIDX_W  = 5;
   localparam int unsigned SFT_W   = 5;

   localparam logic [5:0] FN_NOP   = 6'h00;
   localparam logic [5:0] FN_ADD   = 6'h01;
   localparam logic [5:0] FN_ADDHI = 6'h02;
   localparam logic [5:0] FN_SUB   = 6'h03;
   localparam logic [5:0] FN_SUBHI = 6'h04;
   localparam logic [5:0] FN_AND   = 6'h05;
   localparam logic [5:0] FN_OR    = 6'h06;
   localparam logic [5:0] FN_XOR   = 6'h07;
   localparam logic [5:0] FN_NOT   = 6'h08;
   localparam logic [5:0] FN_SHL   = 6'h09;
   localparam logic [5:0] FN_SHRL  = 6'h0a;
   localparam logic [5:0] FN_SHRA  = 6'h0b;
   localparam logic [5:0] FN_ROTL  = 6'h0c;
   localparam logic [5:0] FN_MUL8  = 6'h0d;
   localparam logic [5:0] FN_MIN   = 6'h0e;
   localparam logic [5:0] FN_MAX   = 6'h0f;
   localparam logic [5:0] FN_CMP   = 6'h10;
   localparam logic [5:0] FN_MOVI  = 6'h11;
   localparam logic [5:0] FN_REG   = 6'h13;
   localparam logic [5:0] FN_MSB   = 6'h14;
   localparam logic [5:0] CTRL_LO  = 6'h14;
   localparam logic [5:0] CTRL_HI  = 6'h17;
   localparam logic [5:0] HDR_LONG = 6'h30;

   typedef struct packed {
      logic [5:0]        opcode;
      logic              rep;
      logic [RIDX_W-1:0] dst;
      logic [5:0]        func;
      logic              reg_form;
      logic              movi;
      logic              ctrl;
      logic              seq;
      logic [IMM_W-1:0]  imm;
      logic [SFT_W-1:0]  shamt;
   } mcx_dec_t;
endpackage

// File: rtl/mcx_decode.sv
module mcx_decode
   import mcx_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output mcx_dec_t           dec
);
   logic [5:0] hdr;
   assign hdr = instr[31:26];

   always_comb begin
      dec = '0;
      // variable-length header: short form carries a repeat bit
      if (hdr < HDR_LONG) begin
         dec.opcode = {1'b0, hdr[5:1]};
         dec.rep    = hdr[0];
      end else begin
         dec.opcode = hdr;
         dec.rep    = 1'b0;
      end
      dec.reg_form = (dec.opcode == FN_REG);
      dec.movi     = (dec.opcode == FN_MOVI);
      dec.ctrl     = (dec.opcode >= CTRL_LO) && (dec.opcode <= CTRL_HI);
      dec.seq      = (dec.opcode >= HDR_LONG);
      dec.imm      = instr[15:0];
      dec.shamt    = instr[25:21];
      if (dec.reg_form) begin
         dec.dst  = instr[15:11];
         dec.func = {1'b0, instr[4:0]};
      end else begin
         dec.dst  = instr[20:16];
         dec.func = (dec.opcode <= FN_CMP) ? dec.opcode : FN_NOP;
      end
   end
endmodule

// File: rtl/mcx_msb.sv
module mcx_msb #(
   parameter  int unsigned W  = 32,
   localparam int unsigned IW = $clog2(W)
) (
   input  logic [W-1:0]  val,
   output logic [IW-1:0] idx
);
   // ascending scan: the last set bit seen is the highest
   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (val[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/mcx_alu.sv
module mcx_alu
   import mcx_pkg::*;
#(
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned SH_W   = $clog2(DATA_W)
) (
   input  logic [5:0]        func,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout,
   output logic              cupd
);
   logic              cin_use;
   logic [DATA_W:0]   add_w;
   logic [DATA_W:0]   sub_rhs;
   logic [SH_W-1:0]   sh;
   logic [2*DATA_W-1:0] rot_w;
   logic [SH_W-1:0]   msb_idx;
   logic [15:0]       prod;

   assign cin_use = ((func == FN_ADDHI) || (func == FN_SUBHI)) && cin;
   assign add_w   = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin_use};
   assign sub_rhs = {1'b0, op_b} + {{DATA_W{1'b0}}, cin_use};
   assign sh      = op_b[SH_W-1:0];
   assign rot_w   = {op_a, op_a} << sh;
   assign prod    = op_a[7:0] * op_b[7:0];
   assign cupd    = (func >= FN_ADD) && (func <= FN_SUBHI);

   mcx_msb #(.W(DATA_W)) u_msb (.val(op_b), .idx(msb_idx));

   always_comb begin
      res  = '0;
      cout = 1'b0;
      case (func)
         FN_ADD, FN_ADDHI: begin
            res  = add_w[DATA_W-1:0];
            cout = add_w[DATA_W];
         end
         FN_SUB, FN_SUBHI: begin
            res  = op_a - op_b - DATA_W'(cin_use);
            cout = ({1'b0, op_a} < sub_rhs);
         end
         FN_AND:  res = op_a & op_b;
         FN_OR:   res = op_a | op_b;
         FN_XOR:  res = op_a ^ op_b;
         FN_NOT:  res = ~op_b;
         FN_SHL:  res = op_a << sh;
         FN_SHRL: res = op_a >> sh;
         FN_SHRA: res = $unsigned($signed(op_a) >>> sh);
         FN_ROTL: res = rot_w[2*DATA_W-1:DATA_W];
         FN_MUL8: res = DATA_W'(prod);
         FN_MIN:  res = (op_a < op_b) ? op_a : op_b;
         FN_MAX:  res = (op_a > op_b) ? op_a : op_b;
         FN_CMP:  res = (op_a == op_b) ? DATA_W'(0) :
                        (op_a > op_b)  ? DATA_W'(1) : DATA_W'(2);
         FN_MSB:  res = DATA_W'(msb_idx);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/mcx_exec_stage.sv
module mcx_exec_stage
   import mcx_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          HAS_CARRY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_en,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   output logic [5:0]         opcode,
   output logic               rep,
   output logic [RIDX_W-1:0]  dst,
   output logic [DATA_W-1:0]  result,
   output logic               ctrl_op,
   output logic               seq_op
);
   generate
      if ((DATA_W < 16) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
         $error("mcx_exec_stage: DATA_W must be a power of two of at least 16");
      end
   endgenerate

   mcx_dec_t          dec;
   logic [DATA_W-1:0] opb_sel;
   logic [DATA_W-1:0] alu_res;
   logic [DATA_W-1:0] movi_res;
   logic              c_q;
   logic              c_nx;
   logic              c_upd;

   mcx_decode u_dec (.instr(instr), .dec(dec));

   assign opb_sel  = dec.reg_form ? src_b : DATA_W'(dec.imm);
   assign movi_res = DATA_W'(dec.imm) << dec.shamt;

   mcx_alu #(.DATA_W(DATA_W)) u_alu (
      .func (dec.func),
      .op_a (src_a),
      .op_b (opb_sel),
      .cin  (c_q),
      .res  (alu_res),
      .cout (c_nx),
      .cupd (c_upd)
   );

   generate
      if (HAS_CARRY) begin : g_carry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               c_q <= 1'b0;
            else if (exec_en && c_upd) c_q <= c_nx;
         end
      end else begin : g_no_carry
         assign c_q = 1'b0;
      end
   endgenerate

   assign opcode  = dec.opcode;
   assign rep     = dec.rep;
   assign dst     = dec.dst;
   assign ctrl_op = dec.ctrl;
   assign seq_op  = dec.seq;
   assign result  = dec.movi ? movi_res : alu_res;
endmodule

// File: rtl/mcx_exec_chk.sv
module mcx_exec_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          HAS_CARRY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_en,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [5:0]        opcode,
   input logic              rep,
   input logic [4:0]        dst,
   input logic [DATA_W-1:0] result,
   input logic              ctrl_op,
   input logic              seq_op
);
   logic [DATA_W:0] imm_sum;
   assign imm_sum = {1'b0, src_a} + {{(DATA_W - 15){1'b0}}, instr[15:0]};

   a_r1_long_header: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[31:26] >= 6'h30) |-> (opcode == instr[31:26] && !rep));

   a_r2_imm_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode >= 6'h01 && opcode <= 6'h10) |-> (dst == instr[20:16]));

   a_r3_reg_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 6'h13) |-> (dst == instr[15:11]));

   a_r4_not_ignores_a: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 6'h13 && instr[4:0] == 5'h08) |-> (result == ~src_b));

   a_r7_cmp_code: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 6'h10) |-> (result < 3));

   a_r8_msb_range: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 6'h13 && instr[4:0] == 5'h14) |-> (result < DATA_W));

   a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_op && seq_op));

   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_op || seq_op || opcode == 6'h00) |-> (result == '0));

   generate
      if (HAS_CARRY) begin : g_carry_chk
         a_r10_carry_chain: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_en && opcode == 6'h01 && imm_sum[DATA_W]) |=>
            ((opcode == 6'h02 && src_a == '0 && instr[15:0] == 16'h0) ? (result == 1) : 1'b1));
      end
   endgenerate
endmodule

bind mcx_exec_stage mcx_exec_chk #(.DATA_W(DATA_W), .HAS_CARRY(HAS_CARRY)) u_chk (
   .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
   .src_a(src_a), .src_b(src_b), .opcode(opcode), .rep(rep), .dst(dst),
   .result(result), .ctrl_op(ctrl_op), .seq_op(seq_op)
);

// File: tb/sim_mcx_exec_stage.sv
module sim_mcx_exec_stage;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [5:0]  opcode;
   logic        rep;
   logic [4:0]  dst;
   logic [31:0] result;
   logic        ctrl_op;
   logic        seq_op;

   int   total = 0;
   int   bad = 0;
   logic mcarry = 1'b0;
   bit   finished = 1'b0;

   always #5 clk = ~clk;

   mcx_exec_stage u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
      .src_a(src_a), .src_b(src_b), .opcode(opcode), .rep(rep), .dst(dst),
      .result(result), .ctrl_op(ctrl_op), .seq_op(seq_op)
   );

   task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic drive(logic [31:0] i, logic [31:0] a, logic [31:0] b, logic en);
      @(negedge clk);
      instr = i; src_a = a; src_b = b; exec_en = en;
      #1;
   endtask

   function automatic logic [32:0] ref_alu(int f, logic [31:0] a, logic [31:0] b, logic c);
      logic [32:0] t;
      int          s;
      s = int'(b[4:0]);
      t = '0;
      case (f)
         1:  t = {1'b0, a} + {1'b0, b};
         2:  t = {1'b0, a} + {1'b0, b} + 33'(c);
         3:  begin t[31:0] = a - b; t[32] = (a < b); end
         4:  begin t[31:0] = a - b - 32'(c); t[32] = (33'(a) < 33'(b) + 33'(c)); end
         5:  t = {1'b0, a & b};
         6:  t = {1'b0, a | b};
         7:  t = {1'b0, a ^ b};
         8:  t = {1'b0, ~b};
         9:  t = {1'b0, a << s};
         10: t = {1'b0, a >> s};
         11: t = {1'b0, $unsigned($signed(a) >>> s)};
         12: t = {1'b0, (a << s) | (a >> (32 - s))};
         13: t = 33'(a[7:0]) * 33'(b[7:0]);
         14: t = {1'b0, (a < b) ? a : b};
         15: t = {1'b0, (a > b) ? a : b};
         16: t = (a == b) ? 33'd0 : (a > b) ? 33'd1 : 33'd2;
         20: for (int k = 0; k < 32; k++) if (b[k]) t = 33'(k);
         default: t = '0;
      endcase
      return t;
   endfunction

   function automatic string req_of(int f);
      if (f >= 1 && f <= 4) return "R4 R10 arith";
      if (f >= 5 && f <= 8) return "R4 logic";
      if (f >= 9 && f <= 12) return "R5 shift";
      if (f >= 13 && f <= 15) return "R6 mul/minmax";
      if (f == 16) return "R7 cmp";
      if (f == 20) return "R8 msb";
      return "R3 unused func";
   endfunction

   task automatic alu_case(logic [31:0] i, logic [31:0] a, logic [31:0] bdrv,
                           logic [31:0] beff, int f, logic [4:0] xdst, string rq);
      logic [32:0] e;
      drive(i, a, bdrv, 1'b1);
      e = ref_alu(f, a, beff, mcarry);
      check(rq, {27'h0, dst, result}, {27'h0, xdst, e[31:0]});
      if (f >= 1 && f <= 4) mcarry = e[32];
   endtask

   logic [31:0] pa [8];
   logic [31:0] pb [8];

   initial begin
      pa = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h5, 32'h7F, 32'hDEAD_BEEF};
      pb = '{32'h0, 32'h1, 32'h1, 32'h7, 32'h9ABC_DEF0, 32'hFFFF_FFFF, 32'hFF, 32'h0000_8123};

      // reset state
      repeat (2) @(negedge clk);
      #1;
      check("R11 reset nop", {32'h0, opcode, rep, ctrl_op, seq_op, result[22:0]}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // header sweep: R1 decode, R11 flags
      for (int h = 0; h < 64; h++) begin
         logic [5:0] xo;
         logic       xr;
         drive({6'(h), 26'h0}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
         xo = (h < 48) ? 6'(h >> 1) : 6'(h);
         xr = (h < 48) ? h[0] : 1'b0;
         check("R1 header decode", {57'h0, opcode, rep}, {57'h0, xo, xr});
         check("R11 flags", {62'h0, ctrl_op, seq_op},
               {62'h0, (xo >= 6'h14 && xo <= 6'h17), (xo >= 6'h30)});
         if (xo >= 6'h14 && !(xo == 6'h13)) begin
            if ((xo <= 6'h17) || (xo >= 6'h30))
               check("R11 no result", {32'h0, result}, 64'h0);
         end
         if (xo == 6'h00) check("R11 nop result", {32'h0, result}, 64'h0);
      end

      // two-register form sweep: R3 and function codes
      for (int f = 0; f < 32; f++) begin
         for (int p = 0; p < 8; p++) begin
            logic [4:0] d;
            d = 5'(f + p);
            alu_case({6'h26, 5'(p * 3), 5'(f), d, 6'h0, 5'(f)},
                     pa[p], pb[p], pb[p], f, d, {"R3 ", req_of(f)});
         end
      end

      // immediate form sweep: R2 (src_b driven with noise)
      for (int f = 1; f <= 16; f++) begin
         for (int p = 0; p < 8; p++) begin
            logic [4:0]  d;
            logic [15:0] im;
            d  = 5'(f ^ p);
            im = pb[p][15:0];
            alu_case({5'(f), p[0], 5'(p), d, im}, pa[p], ~pa[p],
                     {16'h0, im}, f, d, {"R2 ", req_of(f)});
         end
      end

      // move immediate: R9
      for (int s = 0; s < 32; s++) begin
         drive({5'h11, 1'b0, 5'(s), 5'(31 - s), 16'hA5C3}, 32'h1357_9BDF, 32'h2468_ACE0, 1'b0);
         check("R9 movi", {27'h0, dst, result}, {27'h0, 5'(31 - s), 32'h0000_A5C3 << s});
         drive({5'h11, 1'b1, 5'(s), 5'(s), 16'hFFFF}, 32'h0, 32'h0, 1'b0);
         check("R9 movi all ones", {32'h0, result}, {32'h0, 32'h0000_FFFF << s});
      end

      // highest set bit: R8 (src_a ignored)
      for (int k = 0; k < 32; k++) begin
         drive({6'h26, 5'd1, 5'd2, 5'd3, 6'h0, 5'h14}, 32'hFFFF_FFFF, 32'h1 << k, 1'b0);
         check("R8 msb single", {32'h0, result}, 64'(k));
         drive({6'h26, 5'd1, 5'd2, 5'd3, 6'h0, 5'h14}, 32'h0, (32'h1 << k) | 32'h1, 1'b0);
         check("R8 msb with bit0", {32'h0, result}, 64'(k));
      end
      drive({6'h26, 5'd1, 5'd2, 5'd3, 6'h0, 5'h14}, 32'hFFFF_FFFF, 32'h0, 1'b0);
      check("R8 msb zero", {32'h0, result}, 64'h0);

      // NOT ignores first operand: R4
      drive({6'h26, 5'd1, 5'd2, 5'd3, 6'h0, 5'h08}, 32'h0, 32'h0F0F_1234, 1'b0);
      check("R4 not a=0", {32'h0, result}, {32'h0, 32'hF0F0_EDCB});
      drive({6'h26, 5'd1, 5'd2, 5'd3, 6'h0, 5'h08}, 32'hFFFF_FFFF, 32'h0F0F_1234, 1'b0);
      check("R4 not a=ones", {32'h0, result}, {32'h0, 32'hF0F0_EDCB});

      // carry chain: R10
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h01}, 32'hFFFF_FFFF, 32'h1, 1'b1);
      check("R10 low add", {32'h0, result}, 64'h0);
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h03}, 32'h5, 32'h1, 1'b0);
      check("R10 sub no strobe", {32'h0, result}, 64'h4);
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h02}, 32'h0, 32'h0, 1'b0);
      check("R10 carry held", {32'h0, result}, 64'h1);
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h03}, 32'h0, 32'h1, 1'b1);
      check("R10 low sub", {32'h0, result}, {32'h0, 32'hFFFF_FFFF});
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h04}, 32'h5, 32'h0, 1'b1);
      check("R10 borrow used", {32'h0, result}, 64'h4);
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h02}, 32'h0, 32'h0, 1'b0);
      check("R10 borrow cleared", {32'h0, result}, 64'h0);
      drive({6'h02, 5'd0, 5'd1, 16'hFFFF}, 32'hFFFF_0001, 32'h0, 1'b1);
      check("R10 imm add carry", {32'h0, result}, 64'h0);
      drive({6'h04, 5'd0, 5'd1, 16'h0000}, 32'h0, 32'h0, 1'b0);
      check("R10 imm addhi", {32'h0, result}, 64'h1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive({6'h26, 5'd0, 5'd0, 5'd1, 6'h0, 5'h02}, 32'h0, 32'h0, 1'b0);
      check("R10 reset clears carry", {32'h0, result}, 64'h0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule